// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block keeps slot-level insert and removal bookkeeping for several downstream buses and exposes it to firmware through a small 32-bit register window. For each bus it holds three 32-bit words: slots with a new device waiting to be noticed, slots with a removal request waiting to be serviced, and slots that may be removed at all. An 8-bit select register decides which bus the window shows. Firmware polls the pending words after a status event, clears the insert word by reading it, and retires a removal by writing a one-hot (or any non-zero) slot mask to the eject location. Each retirement is passed to the platform as a one-cycle eject strobe that carries the bus and slot.

The platform drives per-bus, per-slot strobes for a plug and for an unplug request, and a per-slot flag for slots whose device must never be removed. Every strobe produces a one-cycle status event for the interrupt logic. After hardware reset, and again whenever the platform raises its reset request, the block works through every pending removal, oldest bus first, ejecting one slot per cycle. It then rebuilds the removable masks from the fixed-slot flags. While this cleanup runs the register port holds off requests. In legacy mode the insert word is not cleared by a read and the select register is pinned to the default bus.

Top module: `hp_slot_bank`

## Requirements
- R1: The window decodes byte offsets 0x00 (insert-pending word), 0x04 (removal-pending word), 0x08 (eject on write, reads 0), 0x0C (removable mask, read-only) and 0x10 (bus select, the low 8 bits of the data). Reads at any other offset return 0, and writes to read-only words change nothing.
- R2: An access has effect only when req_size is 2 (four bytes) and req_addr[1:0] is 0. Any other access is still accepted, returns 0 on a read and changes no state.
- R3: A request is taken in a cycle where req_valid and req_ready are both high. req_ready is low while the reset cleanup runs. Every accepted read gives rsp_valid high for one cycle, the next cycle, with rsp_rdata.
- R4: While the select value is at or above NUM_BUS, every read returns 0 (the select word included) and eject writes do nothing.
- R5: A read of the insert-pending word returns its value and clears it in the same access when legacy_mode is low. When legacy_mode is high it leaves the word unchanged.
- R6: A write to 0x08 with non-zero data takes the lowest set data bit as the slot. It clears that slot in the insert and removal words of the selected bus and pulses eject_valid the next cycle with eject_bus and eject_slot. A zero write does nothing.
- R7: With legacy_mode high, a select write stores DEF_BUS whatever the data is. With it low, the data is stored as written, out-of-range values included.
- R8: A plug strobe (bit bus*32+slot of plug_stb) sets that insert bit, and an unplug strobe sets that removal bit. Any strobe raises event_pulse for one cycle, the next cycle.
- R9: A strobe that lands in the same cycle as a clear of the same word (a read-clear or an eject) leaves its bit set.
- R10: After rst_n or a plat_rst pulse, every pending removal is ejected one per cycle, in order of ascending bus and then ascending slot. Each removable mask is then loaded with the inverse of its fixed_slot bits before req_ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_rst | input | 1 | Platform reset request, starts the cleanup |
| legacy_mode | input | 1 | Keeps insert word on read; pins select to DEF_BUS |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the window |
| req_size | input | 2 | log2 of access bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| plug_stb | input | NUM_BUS*32 | Per-bus, per-slot plug strobes |
| unplug_stb | input | NUM_BUS*32 | Per-bus, per-slot unplug-request strobes |
| fixed_slot | input | NUM_BUS*32 | Slots that are not removable |
| event_pulse | output | 1 | Status event to the interrupt logic |
| eject_valid | output | 1 | Eject strobe |
| eject_bus | output | BUS_W | Bus of the ejected slot |
| eject_slot | output | 5 | Slot of the ejected device |

## Verification
The bench sweeps every slot of every bus through plug, unplug, read-clear and eject. It keeps a per-bus model of all three words and compares every read against it. It aims at the lowest-set-bit choice for eject data with many bits set; a design that took the highest bit, or cleared every set bit, would retire the wrong slot. It covers a plug landing in the very cycle its word is read-cleared, where a design that let the clear win would lose the event. It covers reads and ejects with the select out of range or with a wrong size or alignment, where a leaky design would return data or corrupt another bus. It also records the cleanup's eject order and the mask reload after a changed fixed-slot pattern, which catches a design that skips buses, reorders slots or keeps stale masks.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_INS = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_REM = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_EJ  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RMV = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SEL = 5'h10;
  localparam logic [1:0]        SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {RG_NONE, RG_INS, RG_REM, RG_EJ, RG_RMV, RG_SEL} reg_e;

  typedef struct packed {
    logic              none;
    logic [SLOT_W-1:0] idx;
  } lsb_t;

  function automatic lsb_t lsb_find(input logic [SLOTS-1:0] v);
    lsb_t r;
    r.none = 1'b1;
    r.idx  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.none = 1'b0;
        r.idx  = SLOT_W'(i);
      end
    end
    return r;
  endfunction

  function automatic reg_e reg_decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_INS: return RG_INS;
      OFS_REM: return RG_REM;
      OFS_EJ:  return RG_EJ;
      OFS_RMV: return RG_RMV;
      OFS_SEL: return RG_SEL;
      default: return RG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hp_slot_row.sv
module hp_slot_row
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] plug_i,
  input  logic [SLOTS-1:0] unplug_i,
  input  logic [SLOTS-1:0] fixed_i,
  input  logic             rd_clr_i,
  input  logic [SLOTS-1:0] ej_clr_i,
  input  logic             mask_load_i,
  output logic [SLOTS-1:0] ins_o,
  output logic [SLOTS-1:0] rem_o,
  output logic [SLOTS-1:0] rmv_o
);
  logic [SLOTS-1:0] ins_clr;

  assign ins_clr = {SLOTS{rd_clr_i}} | ej_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_o <= '0;
      rem_o <= '0;
      rmv_o <= '1;
    end else begin
      ins_o <= (ins_o & ~ins_clr) | plug_i;
      rem_o <= (rem_o & ~ej_clr_i) | unplug_i;
      if (mask_load_i) rmv_o <= ~fixed_i;
    end
  end
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [NUM_BUS-1:0][SLOTS-1:0] rem_i,
  output logic                          busy_o,
  output logic                          ej_vld_o,
  output logic [BUS_W-1:0]              ej_bus_o,
  output logic [SLOT_W-1:0]             ej_slot_o,
  output logic                          mask_load_o
);
  typedef enum logic [1:0] {SW_SCAN, SW_LOAD, SW_IDLE} sw_e;
  localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

  sw_e              st_q;
  logic [BUS_W-1:0] idx_q;
  logic [SLOTS-1:0] cur_rem;
  lsb_t             pick;

  always_comb begin
    cur_rem = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (idx_q == BUS_W'(b)) cur_rem = rem_i[b];
    end
  end

  assign pick        = lsb_find(cur_rem);
  assign busy_o      = (st_q != SW_IDLE);
  assign ej_vld_o    = (st_q == SW_SCAN) && !pick.none;
  assign ej_bus_o    = idx_q;
  assign ej_slot_o   = pick.idx;
  assign mask_load_o = (st_q == SW_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_SCAN;
      idx_q <= '0;
    end else begin
      case (st_q)
        SW_SCAN: begin
          if (pick.none) begin
            if (idx_q == LAST_BUS) st_q <= SW_LOAD;
            else                   idx_q <= idx_q + 1'b1;
          end
        end
        SW_LOAD: st_q <= SW_IDLE;
        default: begin
          if (start_i) begin
            st_q  <= SW_SCAN;
            idx_q <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hp_access.sv
module hp_access
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int SEL_W   = 8,
  parameter int BUS_W   = 2,
  parameter int DEF_BUS = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idle_i,
  input  logic                          legacy_i,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [1:0]                    req_size,
  input  logic [31:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  input  logic [NUM_BUS-1:0][SLOTS-1:0] ins_i,
  input  logic [NUM_BUS-1:0][SLOTS-1:0] rem_i,
  input  logic [NUM_BUS-1:0][SLOTS-1:0] rmv_i,
  output logic [SEL_W-1:0]              sel_o,
  output logic [NUM_BUS-1:0]            rd_clr_o,
  output logic                          ej_vld_o,
  output logic [BUS_W-1:0]              ej_bus_o,
  output logic [SLOT_W-1:0]             ej_slot_o
);
  logic             take, good, sel_ok;
  reg_e             which;
  logic [SLOTS-1:0] cur_ins, cur_rem, cur_rmv;
  logic [31:0]      rdata;
  lsb_t             pick;
  logic             clr_en;

  assign req_ready = idle_i;
  assign take      = req_valid && req_ready;
  assign good      = take && (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
  assign which     = reg_decode(req_addr);
  assign sel_ok    = ({1'b0, sel_o} < (SEL_W + 1)'(NUM_BUS));
  assign pick      = lsb_find(req_wdata);

  always_comb begin
    cur_ins = '0;
    cur_rem = '0;
    cur_rmv = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (sel_o == SEL_W'(b)) begin
        cur_ins = ins_i[b];
        cur_rem = rem_i[b];
        cur_rmv = rmv_i[b];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (good && sel_ok && !req_write) begin
      case (which)
        RG_INS:  rdata = cur_ins;
        RG_REM:  rdata = cur_rem;
        RG_RMV:  rdata = cur_rmv;
        RG_SEL:  rdata = 32'(sel_o);
        default: rdata = '0;
      endcase
    end
  end

  assign clr_en = good && !req_write && sel_ok && (which == RG_INS) && !legacy_i;

  always_comb begin
    for (int b = 0; b < NUM_BUS; b++) begin
      rd_clr_o[b] = clr_en && (sel_o == SEL_W'(b));
    end
  end

  assign ej_vld_o  = good && req_write && sel_ok && (which == RG_EJ) && !pick.none;
  assign ej_bus_o  = sel_o[BUS_W-1:0];
  assign ej_slot_o = pick.idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o     <= SEL_W'(DEF_BUS);
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take && !req_write;
      rsp_rdata <= rdata;
      if (good && req_write && which == RG_SEL) begin
        sel_o <= legacy_i ? SEL_W'(DEF_BUS) : req_wdata[SEL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int SEL_W   = 8,
  parameter int DEF_BUS = 0,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int VEC_W  = NUM_BUS * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plat_rst,
  input  logic              legacy_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [VEC_W-1:0]  plug_stb,
  input  logic [VEC_W-1:0]  unplug_stb,
  input  logic [VEC_W-1:0]  fixed_slot,
  output logic              event_pulse,
  output logic              eject_valid,
  output logic [BUS_W-1:0]  eject_bus,
  output logic [4:0]        eject_slot
);
  logic [NUM_BUS-1:0][SLOTS-1:0] ins_arr, rem_arr, rmv_arr, ej_clr;
  logic [VEC_W-1:0]              ins_flat, rem_flat;
  logic [NUM_BUS-1:0]            rd_clr;
  logic [SEL_W-1:0]              sel_q;

  logic                          sw_busy, sw_vld, sw_load;
  logic [BUS_W-1:0]              sw_bus, ac_bus, ej_bus;
  logic [SLOT_W-1:0]             sw_slot, ac_slot, ej_slot;
  logic                          ac_vld, ej_any;

  assign ins_flat = ins_arr;
  assign rem_flat = rem_arr;

  hp_sweep #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (plat_rst),
    .rem_i       (rem_arr),
    .busy_o      (sw_busy),
    .ej_vld_o    (sw_vld),
    .ej_bus_o    (sw_bus),
    .ej_slot_o   (sw_slot),
    .mask_load_o (sw_load)
  );

  hp_access #(.NUM_BUS(NUM_BUS), .SEL_W(SEL_W), .BUS_W(BUS_W), .DEF_BUS(DEF_BUS)) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (!sw_busy),
    .legacy_i  (legacy_mode),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ins_i     (ins_arr),
    .rem_i     (rem_arr),
    .rmv_i     (rmv_arr),
    .sel_o     (sel_q),
    .rd_clr_o  (rd_clr),
    .ej_vld_o  (ac_vld),
    .ej_bus_o  (ac_bus),
    .ej_slot_o (ac_slot)
  );

  assign ej_any  = sw_vld || ac_vld;
  assign ej_bus  = sw_vld ? sw_bus  : ac_bus;
  assign ej_slot = sw_vld ? sw_slot : ac_slot;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_row
    assign ej_clr[b] = (ej_any && ej_bus == BUS_W'(b)) ? (SLOTS'(1) << ej_slot) : '0;

    hp_slot_row u_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .plug_i      (plug_stb[b*SLOTS +: SLOTS]),
      .unplug_i    (unplug_stb[b*SLOTS +: SLOTS]),
      .fixed_i     (fixed_slot[b*SLOTS +: SLOTS]),
      .rd_clr_i    (rd_clr[b]),
      .ej_clr_i    (ej_clr[b]),
      .mask_load_i (sw_load),
      .ins_o       (ins_arr[b]),
      .rem_o       (rem_arr[b]),
      .rmv_o       (rmv_arr[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_pulse <= 1'b0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      event_pulse <= (|plug_stb) || (|unplug_stb);
      eject_valid <= ej_any;
      eject_bus   <= ej_bus;
      eject_slot  <= ej_slot;
    end
  end
endmodule

// File: rtl/hp_slot_bank_chk.sv
module hp_slot_bank_chk #(
  parameter int NUM_BUS = 4,
  parameter int SEL_W   = 8,
  parameter int VEC_W   = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [4:0]       req_addr,
  input logic [1:0]       req_size,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [VEC_W-1:0] plug_stb,
  input logic [VEC_W-1:0] unplug_stb,
  input logic             event_pulse,
  input logic             eject_valid,
  input logic [VEC_W-1:0] ins_flat,
  input logic [VEC_W-1:0] rem_flat,
  input logic [SEL_W-1:0] sel_q
);
  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R8
  event_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|plug_stb) || (|unplug_stb)) |=> event_pulse);

  // R8
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> $past((|plug_stb) || (|unplug_stb)));

  // R9
  plug_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|plug_stb) |=> ((ins_flat & $past(plug_stb)) == $past(plug_stb)));

  // R9
  unplug_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unplug_stb) |=> ((rem_flat & $past(unplug_stb)) == $past(unplug_stb)));

  // R6
  eject_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eject_valid && $past(req_ready)) |->
      $past(req_valid && req_write && req_addr == 5'h08 && req_size == 2'd2));

  // R4
  sel_range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && ({1'b0, sel_q} >= (SEL_W + 1)'(NUM_BUS)))
      |=> (rsp_rdata == 32'd0));

  // R2
  bad_size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_size != 2'd2) |=> !eject_valid);
endmodule

bind hp_slot_bank hp_slot_bank_chk #(.NUM_BUS(NUM_BUS), .SEL_W(SEL_W), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .plug_stb    (plug_stb),
  .unplug_stb  (unplug_stb),
  .event_pulse (event_pulse),
  .eject_valid (eject_valid),
  .ins_flat    (ins_flat),
  .rem_flat    (rem_flat),
  .sel_q       (sel_q)
);

// File: tb/hp_slot_bank_bench.sv
module hp_slot_bank_bench;
  localparam int NB = 4;
  localparam int VW = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          plat_rst = 1'b0;
  logic          legacy_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [4:0]    req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [VW-1:0] plug_stb = '0;
  logic [VW-1:0] unplug_stb = '0;
  logic [VW-1:0] fixed_slot = '0;
  logic          event_pulse;
  logic          eject_valid;
  logic [1:0]    eject_bus;
  logic [4:0]    eject_slot;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] ins_m [NB];
  logic [31:0] rem_m [NB];
  logic [31:0] fix_m [NB];
  logic        l_ev;
  logic [1:0]  l_eb;
  logic [4:0]  l_es;
  logic [31:0] rd;

  always #10 clk = ~clk;

  hp_slot_bank u_hp_slot_bank (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst), .legacy_mode(legacy_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .plug_stb(plug_stb), .unplug_stb(unplug_stb), .fixed_slot(fixed_slot),
    .event_pulse(event_pulse), .eject_valid(eject_valid),
    .eject_bus(eject_bus), .eject_slot(eject_slot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [4:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    l_ev = eject_valid; l_eb = eject_bus; l_es = eject_slot;
    if (!w) chk("R3 rsp_valid after read", 32'(rsp_valid), 32'd1);
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] r);
    access(1'b0, a, 2'd2, 32'd0, r);
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, a, 2'd2, d, dummy);
  endtask

  task automatic strobe(input int b, input int s, input bit unplug);
    @(negedge clk);
    if (unplug) unplug_stb[b*32+s] = 1'b1;
    else        plug_stb[b*32+s]   = 1'b1;
    @(negedge clk);
    plug_stb = '0; unplug_stb = '0;
    chk("R8 event_pulse after strobe", 32'(event_pulse), 32'd1);
    if (unplug) rem_m[b][s] = 1'b1;
    else        ins_m[b][s] = 1'b1;
  endtask

  task automatic apply_fixed();
    for (int b = 0; b < NB; b++) fixed_slot[b*32 +: 32] = fix_m[b];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_b [256];
    int exp_s [256];
    int n_exp, n_seen, guard;

    for (int b = 0; b < NB; b++) begin
      ins_m[b] = '0; rem_m[b] = '0;
      fix_m[b] = (32'h1 << (b * 3 + 1)) | (32'h8000_0000 >> b);
    end
    apply_fixed();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state: masks reloaded from fixed flags, words empty
    for (int b = 0; b < NB; b++) begin
      wr32(5'h10, 32'(b));
      rd32(5'h00, rd); chk("R10 reset insert word", rd, 32'd0);
      rd32(5'h04, rd); chk("R10 reset removal word", rd, 32'd0);
      rd32(5'h0C, rd); chk("R10 reset removable mask", rd, ~fix_m[b]);
      rd32(5'h10, rd); chk("R1 select readback", rd, 32'(b));
      rd32(5'h08, rd); chk("R1 eject offset reads zero", rd, 32'd0);
      rd32(5'h14, rd); chk("R1 undecoded offset reads zero", rd, 32'd0);
    end

    // R8 / R5 sweep of every slot on every bus
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < 32; s++) begin
        strobe(b, s, 1'b0);
        if (s % 2 == 0) strobe(b, (s * 7 + 3) % 32, 1'b1);
      end
    end
    for (int b = 0; b < NB; b++) begin
      wr32(5'h10, 32'(b));
      rd32(5'h00, rd); chk("R8 insert word after plugs", rd, ins_m[b]);
      ins_m[b] = '0;
      rd32(5'h00, rd); chk("R5 insert word cleared by read", rd, 32'd0);
      rd32(5'h04, rd); chk("R8 removal word after unplugs", rd, rem_m[b]);
    end

    // R6 eject picks lowest set bit
    for (int b = 0; b < NB; b++) begin
      wr32(5'h10, 32'(b));
      for (int s = 0; s < 16; s++) begin
        if (s % 4 == 0) strobe(b, s, 1'b0);
        wr32(5'h08, 32'hFFFF_FFFF << s);
        chk("R6 eject_valid", 32'(l_ev), 32'd1);
        chk("R6 eject_bus", 32'(l_eb), 32'(b));
        chk("R6 eject_slot lowest bit", 32'(l_es), 32'(s));
        ins_m[b][s] = 1'b0; rem_m[b][s] = 1'b0;
      end
      rd32(5'h00, rd); chk("R6 insert word after ejects", rd, ins_m[b]);
      rd32(5'h04, rd); chk("R6 removal word after ejects", rd, rem_m[b]);
    end
    wr32(5'h08, 32'd0);
    chk("R6 zero eject write no strobe", 32'(l_ev), 32'd0);
    rd32(5'h04, rd); chk("R6 zero eject keeps removal word", rd, rem_m[NB-1]);

    // R1 read-only words ignore writes
    wr32(5'h04, 32'd0);
    wr32(5'h0C, 32'd0);
    rd32(5'h04, rd); chk("R1 removal word write ignored", rd, rem_m[NB-1]);
    rd32(5'h0C, rd); chk("R1 mask write ignored", rd, ~fix_m[NB-1]);

    // R4 select out of range
    wr32(5'h10, 32'd4);
    for (int a = 0; a < 5; a++) begin
      rd32(5'(a * 4), rd); chk("R4 read with select out of range", rd, 32'd0);
    end
    wr32(5'h08, 32'hFFFF_0000);
    chk("R4 eject ignored out of range", 32'(l_ev), 32'd0);
    wr32(5'h10, 32'd200);
    rd32(5'h10, rd); chk("R4 select read out of range", rd, 32'd0);
    for (int b = 0; b < NB; b++) begin
      wr32(5'h10, 32'(b));
      rd32(5'h04, rd); chk("R4 removal words untouched", rd, rem_m[b]);
    end

    // R2 size and alignment
    wr32(5'h10, 32'd1);
    strobe(1, 20, 1'b0);
    access(1'b0, 5'h00, 2'd1, 32'd0, rd); chk("R2 short read returns zero", rd, 32'd0);
    access(1'b1, 5'h10, 2'd1, 32'd2, rd);
    access(1'b0, 5'h01, 2'd2, 32'd0, rd); chk("R2 misaligned read returns zero", rd, 32'd0);
    access(1'b1, 5'h08, 2'd0, 32'hFFFF_FFFF, rd);
    chk("R2 short eject no strobe", 32'(l_ev), 32'd0);
    rd32(5'h10, rd); chk("R2 short select write ignored", rd, 32'd1);
    rd32(5'h04, rd); chk("R2 removal word intact", rd, rem_m[1]);
    rd32(5'h00, rd); chk("R2 insert word not cleared", rd, ins_m[1]);
    ins_m[1] = '0;

    // R7 / R5 legacy mode
    legacy_mode = 1'b1;
    wr32(5'h10, 32'd3);
    rd32(5'h10, rd); chk("R7 legacy select pinned to default", rd, 32'd0);
    strobe(0, 9, 1'b0);
    rd32(5'h00, rd); chk("R5 legacy read keeps word", rd, ins_m[0]);
    rd32(5'h00, rd); chk("R5 legacy second read", rd, ins_m[0]);
    legacy_mode = 1'b0;
    rd32(5'h00, rd); chk("R5 read clears after legacy off", rd, ins_m[0]);
    ins_m[0] = '0;
    wr32(5'h10, 32'd3);
    rd32(5'h10, rd); chk("R7 select stored as written", rd, 32'd3);

    // R9 plug in the same cycle as read-clear
    wr32(5'h10, 32'd2);
    strobe(2, 4, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h00; req_size = 2'd2;
    plug_stb[2*32+10] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; plug_stb = '0;
    chk("R9 read returns prior word", rsp_rdata, 32'h0000_0010);
    ins_m[2] = 32'h0000_0400;
    rd32(5'h00, rd); chk("R9 new plug survives clear", rd, ins_m[2]);
    ins_m[2] = '0;

    // R10 platform reset cleanup
    strobe(0, 3, 1'b1);
    strobe(2, 7, 1'b1);
    strobe(2, 1, 1'b1);
    strobe(2, 7, 1'b0);
    n_exp = 0;
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < 32; s++) begin
        if (rem_m[b][s]) begin
          exp_b[n_exp] = b; exp_s[n_exp] = s; n_exp++;
          ins_m[b][s] = 1'b0;
        end
      end
      rem_m[b] = '0;
      fix_m[b] = 32'h0000_0F00 << b;
    end
    apply_fixed();
    @(negedge clk); plat_rst = 1'b1;
    @(negedge clk); plat_rst = 1'b0;
    n_seen = 0; guard = 0;
    while (!req_ready && guard < 1000) begin
      if (eject_valid) begin
        if (n_seen < n_exp) begin
          chk("R10 cleanup eject bus order", 32'(eject_bus), 32'(exp_b[n_seen]));
          chk("R10 cleanup eject slot order", 32'(eject_slot), 32'(exp_s[n_seen]));
        end
        n_seen++;
      end
      guard++;
      @(negedge clk);
    end
    chk("R10 cleanup eject count", 32'(n_seen), 32'(n_exp));
    for (int b = 0; b < NB; b++) begin
      wr32(5'h10, 32'(b));
      rd32(5'h04, rd); chk("R10 removal word empty", rd, 32'd0);
      rd32(5'h0C, rd); chk("R10 mask reloaded", rd, ~fix_m[b]);
      rd32(5'h00, rd); chk("R10 insert word after cleanup", rd, ins_m[b]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule